// File: doc/BRIEF.md
# Input Pulse Timestamp Capture

This block records when an external pulse arrives. The time is taken from a free-running reference that counts whole seconds, plus reference-clock cycles within the current second. The pulse line is asynchronous to every clock in the chip. The block first brings the pulse into the reference-clock domain and looks for its rising edge there. On that edge it freezes the current seconds and cycle counts into a tag. It then carries the tag over to the system-clock domain and presents it together with a one-cycle strobe.

The crossing uses a toggle handshake. The reference side flips a request bit when it freezes a tag. The system side notices the flip, copies the tag and flips an acknowledge bit back. Until that acknowledge has returned, the frozen tag is left untouched and any further edge is thrown away. When the time reference is marked as not valid, no tag is produced at all.

Top module: `pulse_stamp`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first system cycle after it, the strobe is low and both tag outputs read zero.
- R2: With the default two-stage synchroniser, a pulse that rises before a reference-clock rising edge is stamped with the seconds and cycle values present on the time inputs at the third reference rising edge after the rise. That tag then appears on the outputs in the system domain.
- R3: If time_ok is low in the reference cycle in which the edge is detected, no strobe follows and the tag outputs keep their previous value.
- R4: Each accepted pulse gives exactly one strobe, and the strobe is high for exactly one system-clock cycle.
- R5: The tag outputs change only in a cycle in which the strobe is high, and hold their value at all other times.
- R6: An edge detected while the previous tag has not yet been acknowledged back to the reference side is dropped: it produces no strobe, and the pending tag is not altered. An edge that arrives after the handshake has completed is accepted again.
- R7: The cycles field of a tag is always below REF_RATE. A pulse stamped just as the cycle count wraps reports cycle 0 and the incremented seconds value.
- R8: Only the rising edge counts. A pulse held high for many reference cycles gives a single tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the time counters advance on it |
| clk_sys | input | 1 | System clock; the tag outputs are delivered on it |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| pulse_async | input | 1 | External pulse, asynchronous to both clocks |
| time_ok | input | 1 | High when the time counters hold a valid time (reference domain) |
| ref_secs | input | 40 | Current seconds count (reference domain) |
| ref_cycles | input | 28 | Current cycle count within the second (reference domain) |
| stamp_secs | output | 40 | Seconds part of the latest tag (system domain) |
| stamp_cycles | output | 28 | Cycles part of the latest tag (system domain) |
| stamp_valid | output | 1 | One-cycle strobe marking a new tag (system domain) |

## Verification
Two things can happen in the same reference cycle: the detection of a new rising edge, and the holding of a tag that is still being handed over. The bench forces this case by ending one pulse and raising a second one only a single reference cycle later. The second edge is therefore detected about three reference cycles after the first tag was frozen, while the acknowledge has not yet come back. The scoreboard expects exactly one tag, carrying the first pulse's time. It then sends a well-spaced pulse to confirm that capture starts working again. A second overlap, a pulse arriving while time_ok is low, is judged the same way: the strobe count must not change and the outputs must hold their values.

// File: rtl/pts_pkg.sv
`timescale 1ns/1ps
package pts_pkg;
    localparam int SEC_W = 40;
    localparam int CYC_W = 28;

    typedef struct packed {
        logic [SEC_W-1:0] secs;
        logic [CYC_W-1:0] cycles;
    } stamp_t;

    localparam stamp_t STAMP_ZERO = '0;

    // a toggle handshake is pending while the two sides disagree
    function automatic logic handoff_open(input logic req, input logic ack);
        return req ^ ack;
    endfunction
endpackage

// File: rtl/pts_sync.sv
`timescale 1ns/1ps
module pts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pts_capture.sv
`timescale 1ns/1ps
module pts_capture
    import pts_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_RATE    = 125000000
) (
    input  logic   clk_ref,
    input  logic   rst,
    input  logic   pulse_async,
    input  logic   time_ok,
    input  stamp_t now,
    input  logic   ack_tgl,
    output logic   req_tgl,
    output stamp_t held
);
    logic pulse_s;
    logic pulse_d;
    logic ack_s;
    logic rise;
    logic busy;
    logic take;

    pts_sync #(.STAGES(SYNC_STAGES)) u_pulse_sync (
        .clk(clk_ref), .rst(rst), .d(pulse_async), .q(pulse_s)
    );

    pts_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_ref), .rst(rst), .d(ack_tgl), .q(ack_s)
    );

    assign rise = pulse_s & ~pulse_d;
    assign busy = handoff_open(req_tgl, ack_s);
    assign take = rise & time_ok & ~busy;

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            pulse_d <= 1'b0;
            req_tgl <= 1'b0;
            held    <= STAMP_ZERO;
        end else begin
            pulse_d <= pulse_s;
            if (take) begin
                held    <= now;
                req_tgl <= ~req_tgl;
            end
        end
    end

    // R6
    busy_hold_chk: assert property (@(posedge clk_ref) disable iff (rst)
        busy |=> $stable(held));

    // R3
    time_gate_chk: assert property (@(posedge clk_ref) disable iff (rst)
        !time_ok |=> $stable(req_tgl));

    // R7
    cycle_range_chk: assert property (@(posedge clk_ref) disable iff (rst)
        take |=> (int'(held.cycles) < REF_RATE));

    // R1
    ref_reset_chk: assert property (@(posedge clk_ref)
        rst |=> (req_tgl == 1'b0 && held == STAMP_ZERO));
endmodule

// File: rtl/pts_deliver.sv
`timescale 1ns/1ps
module pts_deliver
    import pts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk_sys,
    input  logic   rst,
    input  logic   req_tgl,
    input  stamp_t held,
    output logic   ack_tgl,
    output stamp_t stamp_out,
    output logic   strobe
);
    logic req_s;
    logic seen;
    logic fresh;

    pts_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_sys), .rst(rst), .d(req_tgl), .q(req_s)
    );

    assign fresh = handoff_open(req_s, seen);

    always_ff @(posedge clk_sys) begin
        if (rst) begin
            seen      <= 1'b0;
            strobe    <= 1'b0;
            stamp_out <= STAMP_ZERO;
        end else begin
            seen   <= req_s;
            strobe <= fresh;
            if (fresh) stamp_out <= held;
        end
    end

    assign ack_tgl = seen;

    // R4
    one_cycle_strobe_chk: assert property (@(posedge clk_sys) disable iff (rst)
        strobe |=> !strobe);

    // R5
    tag_hold_chk: assert property (@(posedge clk_sys) disable iff (rst)
        !strobe |-> $stable(stamp_out));

    // R1
    sys_reset_chk: assert property (@(posedge clk_sys)
        rst |=> (!strobe && stamp_out == STAMP_ZERO));
endmodule

// File: rtl/pulse_stamp.sv
`timescale 1ns/1ps
module pulse_stamp
    import pts_pkg::*;
#(
    parameter int REF_RATE    = 125000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             pulse_async,
    input  logic             time_ok,
    input  logic [SEC_W-1:0] ref_secs,
    input  logic [CYC_W-1:0] ref_cycles,
    output logic [SEC_W-1:0] stamp_secs,
    output logic [CYC_W-1:0] stamp_cycles,
    output logic             stamp_valid
);
    logic   rst;
    stamp_t now;
    stamp_t held;
    stamp_t stamp_out;
    logic   req_tgl;
    logic   ack_tgl;

    assign rst         = ~rst_n;
    assign now.secs    = ref_secs;
    assign now.cycles  = ref_cycles;

    pts_capture #(.SYNC_STAGES(SYNC_STAGES), .REF_RATE(REF_RATE)) u_capture (
        .clk_ref    (clk_ref),
        .rst        (rst),
        .pulse_async(pulse_async),
        .time_ok    (time_ok),
        .now        (now),
        .ack_tgl    (ack_tgl),
        .req_tgl    (req_tgl),
        .held       (held)
    );

    pts_deliver #(.SYNC_STAGES(SYNC_STAGES)) u_deliver (
        .clk_sys  (clk_sys),
        .rst      (rst),
        .req_tgl  (req_tgl),
        .held     (held),
        .ack_tgl  (ack_tgl),
        .stamp_out(stamp_out),
        .strobe   (stamp_valid)
    );

    assign stamp_secs   = stamp_out.secs;
    assign stamp_cycles = stamp_out.cycles;
endmodule

// File: tb/pulse_stamp_bench.sv
`timescale 1ns/1ps
module pulse_stamp_bench;
    localparam int RATE = 50;

    typedef struct packed {
        logic [39:0] s;
        logic [27:0] c;
    } exp_t;

    logic        clk_ref = 1'b0;
    logic        clk_sys = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pulse   = 1'b0;
    logic        tm_ok   = 1'b1;
    logic [39:0] secs    = 40'h12_3456_7890;
    logic [27:0] cyc     = 28'd0;
    logic [39:0] stamp_secs;
    logic [27:0] stamp_cycles;
    logic        stamp_valid;

    int   checks  = 0;
    int   errors  = 0;
    int   strobes = 0;
    bit   done    = 1'b0;
    bit   prev_valid = 1'b0;
    exp_t last_tag = '0;
    exp_t q[$];

    always #4 clk_ref = ~clk_ref;
    always #5 clk_sys = ~clk_sys;

    // free-running time reference
    always @(posedge clk_ref) begin
        if (cyc == 28'(RATE - 1)) begin
            cyc  <= '0;
            secs <= secs + 40'd1;
        end else begin
            cyc <= cyc + 28'd1;
        end
    end

    pulse_stamp #(.REF_RATE(RATE)) u_pulse_stamp (
        .clk_ref     (clk_ref),
        .clk_sys     (clk_sys),
        .rst_n       (rst_n),
        .pulse_async (pulse),
        .time_ok     (tm_ok),
        .ref_secs    (secs),
        .ref_cycles  (cyc),
        .stamp_secs  (stamp_secs),
        .stamp_cycles(stamp_cycles),
        .stamp_valid (stamp_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: raise the pulse for width reference cycles (width >= 2); the
    // stamp is the time present at the third reference rising edge (R2)
    task automatic fire(input int width, input bit expect_tag);
        exp_t e;
        @(negedge clk_ref);
        pulse = 1'b1;
        repeat (2) @(posedge clk_ref);
        @(negedge clk_ref);
        e.s = secs;
        e.c = cyc;
        if (expect_tag) q.push_back(e);
        for (int i = 2; i < width; i++) @(negedge clk_ref);
        pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk_sys);
    endtask

    // monitor / scoreboard
    always @(negedge clk_sys) begin
        if (rst_n && !done) begin
            if (stamp_valid) begin
                strobes++;
                if (prev_valid) chk(1'b0, "R4 strobe longer than one cycle", 68'd1, 68'd0);
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected tag", {stamp_secs, stamp_cycles}, 68'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({stamp_secs, stamp_cycles} == {e.s, e.c}, "R2 tag value",
                        {stamp_secs, stamp_cycles}, {e.s, e.c});
                end
            end else if ({stamp_secs, stamp_cycles} != last_tag) begin
                chk(1'b0, "R5 tag moved without strobe", {stamp_secs, stamp_cycles}, last_tag);
            end
            prev_valid = stamp_valid;
            last_tag   = {stamp_secs, stamp_cycles};
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        exp_t hold;
        idle(5);
        @(negedge clk_sys);
        // R1
        chk(stamp_valid == 1'b0, "R1 strobe in reset", 68'(stamp_valid), 68'd0);
        chk({stamp_secs, stamp_cycles} == 68'd0, "R1 tag in reset", {stamp_secs, stamp_cycles}, 68'd0);
        rst_n = 1'b1;
        @(negedge clk_sys);
        chk(stamp_valid == 1'b0 && {stamp_secs, stamp_cycles} == 68'd0, "R1 first cycle after reset",
            {stamp_secs, stamp_cycles}, 68'd0);

        // R2, R4: basic pulses of several widths
        base = strobes;
        fire(2, 1'b1); idle(40);
        fire(3, 1'b1); idle(40);
        fire(5, 1'b1); idle(40);
        chk(strobes - base == 3, "R4 one strobe per pulse", 68'(strobes - base), 68'd3);

        // R8: long level gives a single tag
        base = strobes;
        fire(30, 1'b1); idle(40);
        chk(strobes - base == 1, "R8 long pulse", 68'(strobes - base), 68'd1);

        // R3: time not valid
        @(negedge clk_ref);
        tm_ok = 1'b0;
        base = strobes;
        hold = {stamp_secs, stamp_cycles};
        fire(2, 1'b0); idle(40);
        chk(strobes == base, "R3 no strobe while time invalid", 68'(strobes - base), 68'd0);
        chk({stamp_secs, stamp_cycles} == hold, "R3 tag kept", {stamp_secs, stamp_cycles}, hold);
        @(negedge clk_ref);
        tm_ok = 1'b1;

        // R6: second edge during the handshake is dropped
        base = strobes;
        fire(2, 1'b1);
        fire(2, 1'b0);
        idle(40);
        chk(strobes - base == 1, "R6 overlapping edge dropped", 68'(strobes - base), 68'd1);
        base = strobes;
        fire(2, 1'b1); idle(40);
        chk(strobes - base == 1, "R6 capture resumes", 68'(strobes - base), 68'd1);

        // R7: stamp exactly on the cycle wrap
        do @(negedge clk_ref); while (cyc != 28'(RATE - 3));
        base = strobes;
        fire(2, 1'b1); idle(40);
        chk(strobes - base == 1 && stamp_cycles == 28'd0, "R7 wrap stamp",
            68'(stamp_cycles), 68'd0);

        chk(q.size() == 0, "R4 all expected tags seen", 68'(q.size()), 68'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule